// File: doc/BRIEF.md
# Strobe-Handshake FIFO Buffer

This block is a first-in first-out buffer of 64 words, each 5 bits wide. Both sides use a level handshake rather than plain enables. A producer raises its shift-in strobe while the block shows input-ready. A consumer raises its shift-out strobe while the block shows output-ready. The word at the head of the queue always sits in an output register, so the consumer reads it before it asks to move on.

Both strobes may come from outside the block's clock. Each one passes through a synchronizer and is then acted on inside the clock domain. On the write side, `in_rdy` takes the role of "ready" and the shift-in strobe takes the role of "valid". A word is taken at most once for each strobe pulse. When the buffer holds 64 words, `in_rdy` stays low, and a producer that keeps its strobe high is served as soon as a slot frees. On the read side, `out_rdy` takes the role of "valid" and the rising shift-out strobe takes the role of "ready". The consumer acknowledges the word it sees, and the next word is shown only after the strobe has fallen again.

Top module: `strobe_fifo`

## Requirements
- R1: After a synchronous active-high reset, `in_rdy` is 1, `out_rdy` is 0 and `dout` is 0.
- R2: A word is stored only while the synchronized shift-in strobe and `in_rdy` are both high. `in_rdy` goes low after each stored word and stays low until the strobe has been seen low. A strobe held high therefore stores exactly one word.
- R3: The buffer holds 64 words in total, counting the word shown on `dout`. With 64 words held, `in_rdy` is 0.
- R4: If the shift-in strobe is raised while the buffer is full and kept high, no word is taken while full. The word is stored as soon as a read frees a slot.
- R5: While `out_rdy` is 1, `dout` carries the oldest unread word. A rising shift-out strobe seen while `out_rdy` is 1 consumes that word and drives `out_rdy` to 0 on the next clock.
- R6: `dout` keeps its value while the shift-out strobe is high. It changes only in the cycle where `out_rdy` rises, which happens after the strobe has fallen and only if another word is stored.
- R7: When the consumed word was the last one stored, `out_rdy` stays 0 and `dout` keeps that word.
- R8: A rising shift-out strobe seen while `out_rdy` is 0 has no effect. A shift-out strobe that is already high when a word appears does not consume it.
- R9: Words appear on `dout` in the exact order they were stored.
- R10: A store and a consume may happen in the same clock. Both take effect, and the total occupancy is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shin | input | 1 | Shift-in strobe (may be asynchronous) |
| din | input | 5 | Word to store; held stable while `shin` is high |
| in_rdy | output | 1 | Input-ready: a word may be shifted in |
| shout | input | 1 | Shift-out strobe (may be asynchronous) |
| out_rdy | output | 1 | Output-ready: `dout` holds an unread word |
| dout | output | 5 | Head word of the queue |

## Verification
The two functions that can fall in one clock are a store from the shift-in side and the consume of the shown word on the shift-out side. A writer task and a reader task run concurrently, each pulsing its own strobe as fast as its ready flag allows, so the synchronized edges keep landing in the same clock. The scoreboard confirms that every stored word still appears once and in order. A checker confirms that occupancy is unchanged in each cycle where both events fire. The full-and-held case is a second overlap: a consume and a pending store land together, and the bench judges it by the order in which the delayed word later appears.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  localparam int DEF_DEPTH  = 64;
  localparam int DEF_WIDTH  = 5;
  localparam int DEF_STAGES = 2;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign lvl_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 5,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    cnt
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= step(wp);
      if (rd_en) rp <= step(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
endmodule

// File: rtl/sfifo_wr_ctrl.sv
module sfifo_wr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic si_lvl,
  input  logic full,
  output logic in_rdy,
  output logic wr_fire
);
  logic busy;

  assign in_rdy  = !full && !busy;
  assign wr_fire = si_lvl && in_rdy;

  always_ff @(posedge clk) begin
    if (rst)          busy <= 1'b0;
    else if (wr_fire) busy <= 1'b1;
    else if (!si_lvl) busy <= 1'b0;
  end
endmodule

// File: rtl/sfifo_rd_ctrl.sv
module sfifo_rd_ctrl #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             so_lvl,
  input  logic             have_word,
  input  logic [WIDTH-1:0] head,
  output logic             pop,
  output logic             take,
  output logic             so_rise,
  output logic             out_rdy,
  output logic [WIDTH-1:0] dout
);
  logic so_prev, wait_fall;

  assign so_rise = so_lvl && !so_prev;
  assign take    = so_rise && out_rdy;
  assign pop     = !out_rdy && !wait_fall && have_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      so_prev   <= 1'b0;
      wait_fall <= 1'b0;
      out_rdy   <= 1'b0;
      dout      <= '0;
    end else begin
      so_prev <= so_lvl;
      if (take) begin
        out_rdy   <= 1'b0;
        wait_fall <= 1'b1;
      end else if (wait_fall) begin
        if (!so_lvl) wait_fall <= 1'b0;
      end else if (pop) begin
        dout    <= head;
        out_rdy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int DEPTH       = strobe_fifo_pkg::DEF_DEPTH,
  parameter int WIDTH       = strobe_fifo_pkg::DEF_WIDTH,
  parameter int SYNC_STAGES = strobe_fifo_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shin,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shout,
  output logic             out_rdy,
  output logic [WIDTH-1:0] dout
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]       lvl;
  logic             wr_fire, pop, take, so_rise, full;
  logic [WIDTH-1:0] head;
  logic [CW-1:0]    mem_cnt, occ;

  sfifo_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i({shout, shin}), .lvl_o(lvl)
  );

  assign occ  = mem_cnt + CW'(out_rdy);
  assign full = (occ == CW'(DEPTH));

  sfifo_wr_ctrl u_wr (
    .clk(clk), .rst(rst), .si_lvl(lvl[0]), .full(full),
    .in_rdy(in_rdy), .wr_fire(wr_fire)
  );

  sfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_fire), .wr_data(din),
    .rd_en(pop), .rd_data(head), .cnt(mem_cnt)
  );

  sfifo_rd_ctrl #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .so_lvl(lvl[1]), .have_word(mem_cnt != '0),
    .head(head), .pop(pop), .take(take), .so_rise(so_rise),
    .out_rdy(out_rdy), .dout(dout)
  );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [WIDTH-1:0] dout,
  input logic             so_lvl,
  input logic             so_rise,
  input logic             wr_fire,
  input logic             take,
  input logic [CW-1:0]    occ
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      reset_state_chk: assert (in_rdy && !out_rdy && dout == '0);
    end
  end

  // R2
  one_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !in_rdy);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH)) |-> !in_rdy);

  // R5
  consume_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (so_rise && out_rdy) |=> !out_rdy);

  // R6
  dout_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (out_rdy && !$past(out_rdy)));

  // R8
  held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && so_lvl && !so_rise) |=> out_rdy);

  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && take) |=> (occ == $past(occ)));
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_rdy(in_rdy), .out_rdy(out_rdy), .dout(dout),
  .so_lvl(lvl[1]), .so_rise(so_rise), .wr_fire(wr_fire), .take(take),
  .occ(occ)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int W = 5;
  localparam int D = 64;

  logic clk = 1'b0, rst = 1'b1, shin = 1'b0, shout = 1'b0;
  logic [W-1:0] din = '0;
  logic in_rdy, out_rdy;
  logic [W-1:0] dout;
  logic [W-1:0] expq [$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic prev_or = 1'b0;

  always #2 clk = ~clk;

  strobe_fifo u_strobe_fifo (
    .clk(clk), .rst(rst), .shin(shin), .din(din), .in_rdy(in_rdy),
    .shout(shout), .out_rdy(out_rdy), .dout(dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: R9 / R5 order check whenever a new word is shown
  always @(negedge clk) begin
    if (!rst && out_rdy && !prev_or) begin
      if (expq.size() == 0) check(1'b0, "R9 unexpected word", int'(dout), -1);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        check(dout == e, "R9 order", int'(dout), int'(e));
      end
    end
    prev_or <= rst ? 1'b0 : out_rdy;
  end

  task automatic put(input logic [W-1:0] w, input bit hold);
    @(negedge clk);
    while (!in_rdy) @(negedge clk);
    din = w; shin = 1'b1;
    while (in_rdy) @(negedge clk);
    expq.push_back(w);
    if (hold) begin
      repeat (6) @(negedge clk);
      check(in_rdy == 1'b0, "R2 held strobe stores once", int'(in_rdy), 0);
    end
    shin = 1'b0;
  endtask

  task automatic get();
    logic [W-1:0] seen;
    @(negedge clk);
    while (!out_rdy) @(negedge clk);
    seen = dout; shout = 1'b1;
    while (out_rdy) @(negedge clk);
    check(dout == seen, "R6 dout kept while strobe high", int'(dout), int'(seen));
    @(negedge clk);
    shout = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_rdy == 1'b1, "R1 in_rdy", int'(in_rdy), 1);
    check(out_rdy == 1'b0, "R1 out_rdy", int'(out_rdy), 0);
    check(dout == '0, "R1 dout", int'(dout), 0);

    // R2, R5, R6, R7, R9: three words
    put(5'h0A, 1'b1);
    put(5'h0B, 1'b0);
    put(5'h0C, 1'b0);
    repeat (3) get();
    repeat (8) @(negedge clk);
    check(out_rdy == 1'b0, "R7 out_rdy stays low", int'(out_rdy), 0);
    check(dout == 5'h0C, "R7 last word kept", int'(dout), 12);

    // R8: pulse while not ready, then strobe held as a word appears
    shout = 1'b1;
    repeat (6) @(negedge clk);
    shout = 1'b0;
    repeat (6) @(negedge clk);
    check(out_rdy == 1'b0, "R8 ignored pulse", int'(out_rdy), 0);
    check(dout == 5'h0C, "R8 dout untouched", int'(dout), 12);
    shout = 1'b1;
    put(5'h0D, 1'b0);
    while (!out_rdy) @(negedge clk);
    repeat (8) @(negedge clk);
    check(out_rdy == 1'b1, "R8 held strobe no consume", int'(out_rdy), 1);
    shout = 1'b0;
    repeat (4) @(negedge clk);
    check(out_rdy == 1'b1 && dout == 5'h0D, "R8 word still shown", int'(dout), 13);
    get();

    // R3, R4: fill, held write while full
    for (int i = 0; i < D; i++) put(W'(i * 7 + 3), 1'b0);
    repeat (6) @(negedge clk);
    check(in_rdy == 1'b0, "R3 full", int'(in_rdy), 0);
    din = 5'h15; shin = 1'b1;
    expq.push_back(5'h15);
    repeat (6) @(negedge clk);
    check(in_rdy == 1'b0, "R4 no store while full", int'(in_rdy), 0);
    get();
    repeat (12) @(negedge clk);
    check(in_rdy == 1'b0, "R4 stored once slot freed", int'(in_rdy), 0);
    shin = 1'b0;
    repeat (D) get();
    repeat (8) @(negedge clk);
    check(expq.size() == 0, "R9 all words seen", expq.size(), 0);
    check(in_rdy == 1'b1 && out_rdy == 1'b0, "R3 empty again", int'(in_rdy), 1);

    // R10: concurrent stores and consumes
    fork
      for (int i = 0; i < 40; i++) put(W'(i * 11 + 1), 1'b0);
      repeat (40) get();
    join
    repeat (8) @(negedge clk);
    check(expq.size() == 0, "R10 every word delivered", expq.size(), 0);
    check(out_rdy == 1'b0 && in_rdy == 1'b1, "R10 empty at end", int'(out_rdy), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule